// File: doc/BRIEF.md
# Synchronous Queue Transmit Rate Arbiter

This block chooses, each clock cycle, which of two transmit queues on one port may send a beat: a time-critical synchronous queue or a best-effort asynchronous queue. The synchronous queue can be held to a bandwidth budget. An interval timer counts core clock cycles and, each time it expires, refills a byte credit from a limit value counted in 8-byte units. While the credit is spent, the synchronous queue waits for the next refill.

Software loads the interval and the limit through a small write-only register port, then starts rate control through a control register made of one-shot command bits. Other command bits turn the force-sync override on or off, and switch the tie-break rule between the queues. Any scaling of the interval to the core clock is done by software before the write. A start with an inconsistent interval and limit is refused and flagged.

Top module: `sync_rate_arb`

## Requirements
- R1: After reset, both grants are low, force-sync is on (`fsync_active`=1), rate control is stopped (`rc_running`=0), the error flag is clear and tie allocation is off.
- R2: A write to address 2 is a command. Bit 0 turns force-sync on, bit 1 turns it off, bit 2 starts rate control, bit 3 stops it, bit 4 turns tie allocation on and bit 5 turns it off. Zero bits change nothing. When the on and off bits of one pair are both set, the off bit wins.
- R3: A write to address 0 loads the interval (core cycles) and a write to address 1 loads the limit (8-byte units). These values take effect only when rate control is started. A write while rate control runs does not change the budget until the next start.
- R4: A start is refused when the limit is larger than the interval, or when exactly one of the two is zero. The refused start sets `cfg_err` and leaves rate control stopped. An accepted start clears `cfg_err`.
- R5: A start with both interval and limit at zero turns force-sync back on, leaves rate control stopped and does not set `cfg_err`.
- R6: While rate control runs, the credit is refilled to 8 × limit bytes once every interval cycles. Each synchronous grant subtracts `sync_bytes`, saturating at zero. With credit at zero and force-sync off, the synchronous queue is not granted.
- R7: With force-sync on, a requesting synchronous queue is always granted, whatever the credit holds.
- R8: With force-sync off and the synchronous queue eligible, a tie goes to the synchronous queue when allocation is on and to the asynchronous queue when allocation is off.
- R9: At most one grant is high in a cycle. A grant appears one cycle after the request it answers, and only for a queue that requested.
- R10: While rate control is stopped and force-sync is off, the synchronous queue is not limited by credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 interval, 1 limit, 2 command |
| cfg_wdata | input | CFG_W | Register write data |
| sync_req | input | 1 | Synchronous queue requests a beat |
| sync_bytes | input | BEAT_W | Bytes in the synchronous queue's next beat |
| async_req | input | 1 | Asynchronous queue requests a beat |
| grant_sync | output | 1 | Synchronous queue granted (registered) |
| grant_async | output | 1 | Asynchronous queue granted (registered) |
| fsync_active | output | 1 | Force-sync override is on |
| rc_running | output | 1 | Rate control is running |
| cfg_err | output | 1 | Last start was refused for bad configuration |

## Verification
The arbitration is tried with only the synchronous queue requesting, with both queues requesting continuously, and with no requests. Grants are counted over 40-cycle windows, which hold whole intervals at any phase. A lone synchronous stream measures the budget itself: two grants per interval for a limit of 2 at 8 bytes per beat, and four after a restart with a limit of 4. Continuous requests on both queues separate the tie rules: all grants go to the asynchronous queue with allocation off, and eight go to the synchronous queue with allocation on. The same traffic also shows the force-sync and stopped-rate-control overrides. Command writes with both bits of a pair set, and starts with bad or all-zero configurations, check the control decoding through the status outputs.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam logic [1:0] ADDR_INTV = 2'd0;
  localparam logic [1:0] ADDR_LIM  = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  localparam int CB_FS_ON   = 0;
  localparam int CB_FS_OFF  = 1;
  localparam int CB_RC_GO   = 2;
  localparam int CB_RC_HALT = 3;
  localparam int CB_AL_ON   = 4;
  localparam int CB_AL_OFF  = 5;

  typedef struct packed {
    logic fs_on;
    logic fs_off;
    logic rc_go;
    logic rc_halt;
    logic al_on;
    logic al_off;
  } sra_cmd_t;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl import sra_pkg::*; #(
  parameter int CFG_W  = 16,
  parameter int INTV_W = 16,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [INTV_W-1:0] intv_sh,
  output logic [LIM_W-1:0]  lim_sh,
  output logic              go,
  output logic              fsync,
  output logic              alloc,
  output logic              rc_run,
  output logic              err
);
  localparam int CMP_W = (INTV_W > LIM_W) ? INTV_W : LIM_W;

  sra_cmd_t cmd;
  logic     cmd_wr;
  logic     bad_cfg, zero_cfg, start_req;
  logic [CMP_W-1:0] intv_x, lim_x;

  always_comb begin
    cmd.fs_on   = cfg_wdata[CB_FS_ON];
    cmd.fs_off  = cfg_wdata[CB_FS_OFF];
    cmd.rc_go   = cfg_wdata[CB_RC_GO];
    cmd.rc_halt = cfg_wdata[CB_RC_HALT];
    cmd.al_on   = cfg_wdata[CB_AL_ON];
    cmd.al_off  = cfg_wdata[CB_AL_OFF];
  end

  assign cmd_wr    = cfg_wr && (cfg_addr == ADDR_CMD);
  assign intv_x    = CMP_W'(intv_sh);
  assign lim_x     = CMP_W'(lim_sh);
  assign zero_cfg  = (intv_sh == '0) && (lim_sh == '0);
  assign bad_cfg   = (lim_x > intv_x) || ((intv_sh == '0) != (lim_sh == '0));
  assign start_req = cmd_wr && cmd.rc_go && !cmd.rc_halt;
  assign go        = start_req && !bad_cfg && !zero_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      intv_sh <= '0;
      lim_sh  <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == ADDR_INTV) intv_sh <= cfg_wdata[INTV_W-1:0];
      if (cfg_addr == ADDR_LIM)  lim_sh  <= cfg_wdata[LIM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync  <= 1'b1;
      alloc  <= 1'b0;
      rc_run <= 1'b0;
      err    <= 1'b0;
    end else if (cmd_wr) begin
      if (cmd.fs_off)     fsync <= 1'b0;
      else if (cmd.fs_on) fsync <= 1'b1;
      if (cmd.al_off)     alloc <= 1'b0;
      else if (cmd.al_on) alloc <= 1'b1;
      if (cmd.rc_halt) begin
        rc_run <= 1'b0;
      end else if (cmd.rc_go) begin
        if (bad_cfg) begin
          err <= 1'b1;
        end else if (zero_cfg) begin
          fsync  <= 1'b1;
          rc_run <= 1'b0;
          err    <= 1'b0;
        end else begin
          rc_run <= 1'b1;
          err    <= 1'b0;
        end
      end
    end
  end

  // R2: clear bit of the force-sync pair wins over the set bit
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd.fs_on && cmd.fs_off) |=> !fsync);
  // R4: refused start flags the error and does not start from a stopped state
  a_r4_refuse: assert property (@(posedge clk) disable iff (rst)
    (start_req && bad_cfg && !rc_run) |=> (err && !rc_run));
  // R5: all-zero start restores force-sync
  a_r5_zero_restore: assert property (@(posedge clk) disable iff (rst)
    (start_req && zero_cfg) |=> (fsync && !rc_run && !err));
endmodule

// File: rtl/sra_credit.sv
module sra_credit #(
  parameter int INTV_W = 16,
  parameter int LIM_W  = 16,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              rc_run,
  input  logic [INTV_W-1:0] intv_sh,
  input  logic [LIM_W-1:0]  lim_sh,
  input  logic              take,
  input  logic [BEAT_W-1:0] take_bytes,
  output logic              credit_nz
);
  localparam int CR_W = LIM_W + 3;

  logic [INTV_W-1:0] act_intv, timer;
  logic [LIM_W-1:0]  act_lim;
  logic [CR_W-1:0]   credit, take_x, refill;

  assign take_x    = CR_W'(take_bytes);
  assign refill    = {act_lim, 3'b000};
  assign credit_nz = (credit != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_intv <= '0;
      act_lim  <= '0;
      timer    <= '0;
      credit   <= '0;
    end else if (go) begin
      act_intv <= intv_sh;
      act_lim  <= lim_sh;
      timer    <= intv_sh;
      credit   <= {lim_sh, 3'b000};
    end else if (rc_run) begin
      if (timer <= INTV_W'(1)) begin
        timer  <= act_intv;
        credit <= refill;
      end else begin
        timer <= timer - INTV_W'(1);
        if (take) credit <= (credit > take_x) ? (credit - take_x) : '0;
      end
    end
  end

  // R6: credit never exceeds the refill amount of the active limit
  a_r6_credit_cap: assert property (@(posedge clk) disable iff (rst)
    rc_run |-> (credit <= refill));
  // R6: timer never idles at zero while running
  a_r6_timer_live: assert property (@(posedge clk) disable iff (rst)
    rc_run |-> (timer != '0));
endmodule

// File: rtl/sra_pick.sv
module sra_pick (
  input  logic clk,
  input  logic rst,
  input  logic sync_req,
  input  logic async_req,
  input  logic fsync,
  input  logic alloc,
  input  logic rc_run,
  input  logic credit_nz,
  output logic take,
  output logic grant_sync,
  output logic grant_async
);
  logic sync_ok, pick_s, pick_a;

  assign sync_ok = fsync || !rc_run || credit_nz;
  assign pick_s  = sync_req && sync_ok && (fsync || alloc || !async_req);
  assign pick_a  = async_req && !pick_s;
  assign take    = pick_s && rc_run && !fsync;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_sync  <= 1'b0;
      grant_async <= 1'b0;
    end else begin
      grant_sync  <= pick_s;
      grant_async <= pick_a;
    end
  end

  // R9: mutually exclusive grants, only to a requester of the previous cycle
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_sync, grant_async}));
  a_r9_sync_req: assert property (@(posedge clk) disable iff (rst)
    grant_sync |-> $past(sync_req));
  a_r9_async_req: assert property (@(posedge clk) disable iff (rst)
    grant_async |-> $past(async_req));
  // R6: spent credit blocks the synchronous queue
  a_r6_no_credit: assert property (@(posedge clk) disable iff (rst)
    (rc_run && !fsync && !credit_nz && sync_req) |=> !grant_sync);
  // R7: force-sync always serves a synchronous request
  a_r7_force: assert property (@(posedge clk) disable iff (rst)
    (fsync && sync_req) |=> grant_sync);
endmodule

// File: rtl/sync_rate_arb.sv
module sync_rate_arb #(
  parameter int CFG_W  = 16,
  parameter int INTV_W = 16,
  parameter int LIM_W  = 16,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              sync_req,
  input  logic [BEAT_W-1:0] sync_bytes,
  input  logic              async_req,
  output logic              grant_sync,
  output logic              grant_async,
  output logic              fsync_active,
  output logic              rc_running,
  output logic              cfg_err
);
  logic [INTV_W-1:0] intv_sh;
  logic [LIM_W-1:0]  lim_sh;
  logic go, fsync, alloc, rc_run, err, credit_nz, take;

  sra_ctrl #(.CFG_W(CFG_W), .INTV_W(INTV_W), .LIM_W(LIM_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .intv_sh(intv_sh), .lim_sh(lim_sh), .go(go),
    .fsync(fsync), .alloc(alloc), .rc_run(rc_run), .err(err)
  );

  sra_credit #(.INTV_W(INTV_W), .LIM_W(LIM_W), .BEAT_W(BEAT_W)) u_credit (
    .clk(clk), .rst(rst), .go(go), .rc_run(rc_run), .intv_sh(intv_sh),
    .lim_sh(lim_sh), .take(take), .take_bytes(sync_bytes),
    .credit_nz(credit_nz)
  );

  sra_pick u_pick (
    .clk(clk), .rst(rst), .sync_req(sync_req), .async_req(async_req),
    .fsync(fsync), .alloc(alloc), .rc_run(rc_run), .credit_nz(credit_nz),
    .take(take), .grant_sync(grant_sync), .grant_async(grant_async)
  );

  assign fsync_active = fsync;
  assign rc_running   = rc_run;
  assign cfg_err      = err;
endmodule

// File: tb/sync_rate_arb_tb.sv
module sync_rate_arb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        sync_req, async_req;
  logic [7:0]  sync_bytes;
  logic        grant_sync, grant_async, fsync_active, rc_running, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [15:0] FS_ON = 16'h01, FS_OFF = 16'h02, GO = 16'h04,
                          HALT = 16'h08, AL_ON = 16'h10, AL_OFF = 16'h20;

  always #2 clk = ~clk;

  sync_rate_arb u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_req(sync_req), .sync_bytes(sync_bytes),
    .async_req(async_req), .grant_sync(grant_sync), .grant_async(grant_async),
    .fsync_active(fsync_active), .rc_running(rc_running), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic count(input int n, output int gs, output int ga);
    gs = 0; ga = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gs += grant_sync;
      ga += grant_async;
    end
  endtask

  task automatic setup(input int intv, input int lim, input logic [15:0] extra);
    wr(2'd2, HALT);
    wr(2'd0, 16'(intv));
    wr(2'd1, 16'(lim));
    wr(2'd2, GO | FS_OFF | extra);
  endtask

  task automatic t_reset;
    check("R1 grant_sync", grant_sync, 0);
    check("R1 grant_async", grant_async, 0);
    check("R1 fsync", fsync_active, 1);
    check("R1 rc_running", rc_running, 0);
    check("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_idle_and_latency;
    int gs, ga;
    count(5, gs, ga);
    check("R9 no request no grant", gs + ga, 0);
    sync_req = 1'b1;
    @(negedge clk);
    check("R9/R7 grant one cycle after request", grant_sync, 1);
    sync_req = 1'b0;
    @(negedge clk);
    check("R9 grant drops after request", grant_sync, 0);
  endtask

  task automatic t_budget;
    int gs, ga;
    sync_req = 1'b1; async_req = 1'b0;
    setup(10, 2, 16'h0);
    check("R6 running", rc_running, 1);
    count(40, gs, ga);
    check("R6 sync grants per 40 cycles, limit 2", gs, 8);
    wr(2'd1, 16'd4);
    count(40, gs, ga);
    check("R3 limit write while running ignored", gs, 8);
    wr(2'd2, HALT);
    wr(2'd2, GO);
    count(40, gs, ga);
    check("R3 new limit after restart", gs, 16);
  endtask

  task automatic t_ties;
    int gs, ga;
    sync_req = 1'b1; async_req = 1'b1;
    setup(10, 2, AL_OFF);
    count(40, gs, ga);
    check("R8 alloc off sync grants", gs, 0);
    check("R8 alloc off async grants", ga, 40);
    setup(10, 2, AL_ON);
    count(40, gs, ga);
    check("R8 alloc on sync grants", gs, 8);
    check("R8 alloc on async grants", ga, 32);
    wr(2'd2, FS_ON | AL_OFF);
    count(40, gs, ga);
    check("R7 force-sync sync grants", gs, 40);
    wr(2'd2, HALT | FS_OFF | AL_ON);
    count(40, gs, ga);
    check("R10 stopped, unlimited sync grants", gs, 40);
    sync_req = 1'b0; async_req = 1'b0;
  endtask

  task automatic t_config;
    wr(2'd2, HALT | FS_OFF);
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd5);
    wr(2'd2, GO);
    check("R4 limit above interval flagged", cfg_err, 1);
    check("R4 limit above interval not started", rc_running, 0);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd3);
    wr(2'd2, GO);
    check("R4 single zero flagged", cfg_err, 1);
    check("R4 single zero not started", rc_running, 0);
    wr(2'd0, 16'd6);
    wr(2'd2, GO);
    check("R4 good start clears error", cfg_err, 0);
    check("R4 good start runs", rc_running, 1);
    wr(2'd2, GO | HALT);
    check("R2 stop beats start", rc_running, 0);
    wr(2'd2, FS_ON | FS_OFF);
    check("R2 force-sync off beats on", fsync_active, 0);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, GO);
    check("R5 zero start restores force-sync", fsync_active, 1);
    check("R5 zero start stays stopped", rc_running, 0);
    check("R5 zero start no error", cfg_err, 0);
  endtask

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sync_req = 1'b0; async_req = 1'b0; sync_bytes = 8'd8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_idle_and_latency;
    t_budget;
    t_ties;
    t_config;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule